// File: doc/BRIEF.md
# Time-Triggered Virtual-Link Send Scheduler

This block holds descriptors of outgoing time-triggered frames and releases each one at a fixed point of a repeating cluster cycle. Every virtual link (VL) has its own queue and its own timing, all set at elaboration: an identifier, a send offset counted from the start of the cluster cycle, and a send period that divides the cluster length. Software pushes a descriptor (buffer address, frame length, VL index) and, one cycle later, gets back whether it was taken or refused. The block does not hold frame data. It only forwards descriptors to a MAC through a one-cycle transmit request.

The timing comes from an external synchronized time base. It gives the position inside the cluster cycle, together with a flag that says whether that position can be trusted. The flag stays low until clock synchronization has first locked. A VL's send slot is reached when the cluster time, minus the VL's offset and taken modulo the cluster length, is a multiple of the VL's period. Each queue is deep enough for exactly one cluster cycle of that VL's slots. A descriptor is sent only at a slot, never simply because it is present. It therefore waits at most one cluster cycle.

Top module: `tt_vl_send_sched`

## Requirements
- R1: After reset, `tx_valid` and `enq_done` are low and every queue is empty.
- R2: Each cycle with `enq_valid` high is answered in the next cycle with `enq_done` high for one cycle. `enq_ok` is 1 when the descriptor was stored.
- R3: VL `v` holds at most `CLUSTER_LEN / VL_PERIOD[v]` descriptors. An enqueue to a full VL, or to a VL index of `NUM_VL` or above, answers `enq_ok` = 0 and stores nothing.
- R4: A slot of VL `v` is reached in a cycle where `time_valid` is high and `cyc_time` holds a new value t < `CLUSTER_LEN` with (t − `VL_OFFSET[v]`) mod `CLUSTER_LEN` mod `VL_PERIOD[v]` = 0. If the queue is then non-empty, its head descriptor appears on `tx_addr`/`tx_len` with `tx_valid` high for one cycle, two cycles after that cycle at the earliest.
- R5: A slot reached while its VL's queue is empty sends nothing and is not carried over. A descriptor enqueued after the slot waits for the next slot of its VL.
- R6: When several VLs reach a slot in the same cycle, their frames are issued one per cycle in ascending VL index. The lowest index goes out in the first issue cycle.
- R7: While `time_valid` is low, enqueues are still answered and stored, but no slot is reached.
- R8: Descriptors of one VL leave in the order they were accepted, with the address and length they were given.
- R9: A `cyc_time` value held for several cycles counts as one time point and reaches each matching slot only once. A slot is reached again only after the value changes, or after `time_valid` falls and rises.
- R10: `tx_vl_id` carries the configured identifier `VL_ID[v]` of the VL whose frame is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_time | input | TIME_W | Synchronized position within the cluster cycle |
| time_valid | input | 1 | Time base is synchronized and running |
| enq_valid | input | 1 | Enqueue request this cycle |
| enq_addr | input | ADDR_W | Frame buffer address |
| enq_len | input | LEN_W | Frame length |
| enq_vl | input | VLW | Target VL index |
| enq_done | output | 1 | Response to last cycle's enqueue |
| enq_ok | output | 1 | 1 = accepted, 0 = refused |
| tx_valid | output | 1 | One-cycle transmit request |
| tx_addr | output | ADDR_W | Address of the frame to send |
| tx_len | output | LEN_W | Length of the frame to send |
| tx_vl_id | output | ID_W | Identifier of the sending VL |

## Verification
The hardest situation to create is a slot collision that hits queues that are partly full, and then empty slots in the following cluster cycle. Queues only drain at slot instants, so reaching that state takes prefilling under an invalid time base and then a full synchronized cluster. The bench works from a small three-VL configuration whose slot times coincide at two points of a 24-tick cluster. It fills every queue past its depth while the time flag is low, and then sweeps three complete clusters tick by tick. Along the way it enqueues just before and just after slots. A reference model computed from the slot formula predicts the response and transmit output of every cycle, including held time values and a restart of the time flag.

// File: rtl/tt_sched_pkg.sv
package tt_sched_pkg;

   // Width of an index into n items, at least one bit.
   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // Number of bits needed to count 0..n inclusive.
   function automatic int unsigned cnt_width(input int unsigned n);
      return $clog2(n + 1);
   endfunction

endpackage

// File: rtl/tt_vl_fifo.sv
module tt_vl_fifo #(
   parameter int unsigned DEPTH  = 2,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CNT_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [CNT_W-1:0]  count,
   output logic              full,
   output logic              empty
);

   logic do_push;
   logic do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CNT_W'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   generate
      if (DEPTH == 1) begin : g_single
         logic              held;
         logic [DATA_W-1:0] slot_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               held   <= 1'b0;
               slot_q <= '0;
            end else begin
               if (do_pop)
                  held <= 1'b0;
               if (do_push) begin
                  held   <= 1'b1;
                  slot_q <= wdata;
               end
            end
         end

         assign rdata = slot_q;
         assign count = CNT_W'(held);
      end else begin : g_ring
         localparam int unsigned PW = $clog2(DEPTH);

         logic [DATA_W-1:0] mem [DEPTH];
         logic [PW-1:0]     wp;
         logic [PW-1:0]     rp;
         logic [CNT_W-1:0]  cnt_q;

         function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
            return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
         endfunction

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wp    <= '0;
               rp    <= '0;
               cnt_q <= '0;
            end else begin
               if (do_push)
                  wp <= bump(wp);
               if (do_pop)
                  rp <= bump(rp);
               if (do_push && !do_pop)
                  cnt_q <= cnt_q + 1'b1;
               else if (do_pop && !do_push)
                  cnt_q <= cnt_q - 1'b1;
            end
         end

         always_ff @(posedge clk) begin
            if (do_push)
               mem[wp] <= wdata;
         end

         assign rdata = mem[rp];
         assign count = cnt_q;
      end
   endgenerate

endmodule

// File: rtl/tt_slot_detect.sv
module tt_slot_detect #(
   parameter int unsigned TIME_W  = 8,
   parameter int unsigned CLUSTER = 24,
   parameter int unsigned OFFSET  = 0,
   parameter int unsigned PERIOD  = 24
) (
   input  logic [TIME_W-1:0] cyc_time,
   input  logic              arm,
   output logic              hit
);

   localparam int unsigned W = TIME_W + 1;

   logic [W-1:0] t_ext;
   logic [W-1:0] since_off;

   always_comb begin
      t_ext = {1'b0, cyc_time};
      if (t_ext >= W'(OFFSET))
         since_off = t_ext - W'(OFFSET);
      else
         since_off = t_ext + W'(CLUSTER) - W'(OFFSET);
      hit = arm && (t_ext < W'(CLUSTER)) && ((since_off % W'(PERIOD)) == '0);
   end

endmodule

// File: rtl/tt_lowest_first.sv
module tt_lowest_first #(
   parameter int unsigned N  = 2,
   parameter int unsigned IW = 1
) (
   input  logic [N-1:0]  req,
   output logic [N-1:0]  grant,
   output logic [IW-1:0] idx,
   output logic          any
);

   always_comb begin
      grant = '0;
      idx   = '0;
      any   = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !any) begin
            grant[i] = 1'b1;
            idx      = IW'(i);
            any      = 1'b1;
         end
      end
   end

endmodule

// File: rtl/tt_vl_send_sched.sv
module tt_vl_send_sched
   import tt_sched_pkg::*;
#(
   parameter int unsigned NUM_VL      = 2,
   parameter int unsigned TIME_W      = 8,
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned LEN_W       = 11,
   parameter int unsigned ID_W        = 16,
   parameter int unsigned CLUSTER_LEN = 200,
   parameter int unsigned VL_PERIOD [NUM_VL] = '{200, 100},
   parameter int unsigned VL_OFFSET [NUM_VL] = '{100, 82},
   parameter int unsigned VL_ID     [NUM_VL] = '{16'h0011, 16'h0022},
   localparam int unsigned VLW = idx_width(NUM_VL)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] cyc_time,
   input  logic              time_valid,
   input  logic              enq_valid,
   input  logic [ADDR_W-1:0] enq_addr,
   input  logic [LEN_W-1:0]  enq_len,
   input  logic [VLW-1:0]    enq_vl,
   output logic              enq_done,
   output logic              enq_ok,
   output logic              tx_valid,
   output logic [ADDR_W-1:0] tx_addr,
   output logic [LEN_W-1:0]  tx_len,
   output logic [ID_W-1:0]   tx_vl_id
);

   function automatic int unsigned deepest();
      int unsigned m = 1;
      for (int i = 0; i < NUM_VL; i++)
         if (CLUSTER_LEN / VL_PERIOD[i] > m)
            m = CLUSTER_LEN / VL_PERIOD[i];
      return m;
   endfunction

   localparam int unsigned DW    = ADDR_W + LEN_W;
   localparam int unsigned MAXD  = deepest();
   localparam int unsigned CNT_W = cnt_width(MAXD);

   // Elaboration-time parameter checks
   generate
      if (NUM_VL < 1) begin : g_bad_num
         $error("NUM_VL must be at least 1");
      end
      if (CLUSTER_LEN < 1 || CLUSTER_LEN >= (1 << TIME_W)) begin : g_bad_cl
         $error("CLUSTER_LEN must fit in TIME_W bits");
      end
      for (genvar c = 0; c < NUM_VL; c++) begin : g_cfg_chk
         if (VL_PERIOD[c] == 0 || (CLUSTER_LEN % VL_PERIOD[c]) != 0) begin : g_bad_per
            $error("VL period must divide the cluster length");
         end
         if (VL_OFFSET[c] >= VL_PERIOD[c]) begin : g_bad_off
            $error("VL offset must be below its period");
         end
         if (VL_ID[c] >= (1 << ID_W)) begin : g_bad_id
            $error("VL identifier does not fit ID_W");
         end
      end
   endgenerate

   // Time point tracking: a slot is reached once per new time value
   logic [TIME_W-1:0] prev_time;
   logic              prev_valid;
   logic              new_point;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_time  <= '0;
         prev_valid <= 1'b0;
      end else begin
         prev_time  <= cyc_time;
         prev_valid <= time_valid;
      end
   end

   assign new_point = time_valid && (!prev_valid || (cyc_time != prev_time));

   // Per-VL queue and slot detection
   logic [NUM_VL-1:0]        hit;
   logic [NUM_VL-1:0]        q_full;
   logic [NUM_VL-1:0]        q_empty;
   logic [NUM_VL-1:0]        push;
   logic [NUM_VL-1:0]        grant;
   logic [NUM_VL-1:0]        pend_q;
   logic [DW-1:0]            head [NUM_VL];
   logic [NUM_VL*CNT_W-1:0]  cnt_flat;

   generate
      for (genvar v = 0; v < NUM_VL; v++) begin : g_vl
         localparam int unsigned QD = CLUSTER_LEN / VL_PERIOD[v];
         logic [CNT_W-1:0] cnt;

         tt_slot_detect #(
            .TIME_W (TIME_W),
            .CLUSTER(CLUSTER_LEN),
            .OFFSET (VL_OFFSET[v]),
            .PERIOD (VL_PERIOD[v])
         ) u_slot (
            .cyc_time(cyc_time),
            .arm     (new_point),
            .hit     (hit[v])
         );

         assign push[v] = enq_valid && (enq_vl == VLW'(v)) && !q_full[v];

         tt_vl_fifo #(
            .DEPTH (QD),
            .DATA_W(DW),
            .CNT_W (CNT_W)
         ) u_q (
            .clk  (clk),
            .rst_n(rst_n),
            .push (push[v]),
            .pop  (grant[v]),
            .wdata({enq_addr, enq_len}),
            .rdata(head[v]),
            .count(cnt),
            .full (q_full[v]),
            .empty(q_empty[v])
         );

         assign cnt_flat[v*CNT_W +: CNT_W] = cnt;
      end
   endgenerate

   // Issue arbitration: lowest pending VL first
   logic [VLW-1:0] grant_idx;
   logic           grant_any;

   tt_lowest_first #(
      .N (NUM_VL),
      .IW(VLW)
   ) u_arb (
      .req  (pend_q),
      .grant(grant),
      .idx  (grant_idx),
      .any  (grant_any)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= '0;
      else
         pend_q <= (pend_q & ~grant) | (hit & ~q_empty);
   end

   // Selected head and identifier
   logic [DW-1:0]   sel_head;
   logic [ID_W-1:0] sel_id;
   logic            sel_full;

   always_comb begin
      sel_head = '0;
      sel_id   = '0;
      for (int i = 0; i < NUM_VL; i++) begin
         if (grant[i]) begin
            sel_head = head[i];
            sel_id   = ID_W'(VL_ID[i]);
         end
      end
   end

   always_comb begin
      sel_full = 1'b1;
      for (int i = 0; i < NUM_VL; i++)
         if (enq_vl == VLW'(i))
            sel_full = q_full[i];
   end

   // Registered outputs
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_valid <= 1'b0;
         tx_addr  <= '0;
         tx_len   <= '0;
         tx_vl_id <= '0;
         enq_done <= 1'b0;
         enq_ok   <= 1'b0;
      end else begin
         tx_valid <= grant_any;
         if (grant_any) begin
            tx_addr  <= sel_head[DW-1:LEN_W];
            tx_len   <= sel_head[LEN_W-1:0];
            tx_vl_id <= sel_id;
         end
         enq_done <= enq_valid;
         enq_ok   <= enq_valid && !sel_full;
      end
   end

   // Otherwise unused in this variant
   logic unused_idx;
   assign unused_idx = ^grant_idx;

endmodule

// File: rtl/tt_vl_send_sched_chk.sv
module tt_vl_send_sched_chk #(
   parameter int unsigned NUM_VL      = 2,
   parameter int unsigned CNT_W       = 2,
   parameter int unsigned CLUSTER_LEN = 200,
   parameter int unsigned VL_PERIOD [NUM_VL] = '{200, 100}
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    time_valid,
   input logic                    enq_valid,
   input logic                    enq_done,
   input logic                    tx_valid,
   input logic [NUM_VL-1:0]       pend,
   input logic [NUM_VL-1:0]       grant,
   input logic [NUM_VL*CNT_W-1:0] cnt_flat
);

   assert_enq_answered_R2: assert property (@(posedge clk) disable iff (!rst_n)
      enq_valid |=> enq_done);

   assert_tx_from_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> $past(|pend));

   assert_one_issue_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   assert_no_slot_invalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|(pend & ~$past(pend))) |-> $past(time_valid));

   generate
      for (genvar v = 0; v < NUM_VL; v++) begin : g_ovf
         assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_flat[v*CNT_W +: CNT_W] <= CNT_W'(CLUSTER_LEN / VL_PERIOD[v]));
      end
   endgenerate

endmodule

bind tt_vl_send_sched tt_vl_send_sched_chk #(
   .NUM_VL     (NUM_VL),
   .CNT_W      (CNT_W),
   .CLUSTER_LEN(CLUSTER_LEN),
   .VL_PERIOD  (VL_PERIOD)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .time_valid(time_valid),
   .enq_valid (enq_valid),
   .enq_done  (enq_done),
   .tx_valid  (tx_valid),
   .pend      (pend_q),
   .grant     (grant),
   .cnt_flat  (cnt_flat)
);

// File: tb/tb_tt_vl_send_sched.sv
module tb_tt_vl_send_sched;

   localparam int unsigned NV = 3;
   localparam int unsigned TW = 8;
   localparam int unsigned AW = 16;
   localparam int unsigned LW = 11;
   localparam int unsigned IW = 16;
   localparam int unsigned CL = 24;
   localparam int unsigned PER [NV] = '{12, 8, 24};
   localparam int unsigned OFF [NV] = '{2, 2, 10};
   localparam int unsigned IDS [NV] = '{16'h00A1, 16'h00B2, 16'h00C3};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [TW-1:0] cyc_time = '0;
   logic          time_valid = 1'b0;
   logic          enq_valid = 1'b0;
   logic [AW-1:0] enq_addr = '0;
   logic [LW-1:0] enq_len = '0;
   logic [1:0]    enq_vl = '0;
   logic          enq_done, enq_ok, tx_valid;
   logic [AW-1:0] tx_addr;
   logic [LW-1:0] tx_len;
   logic [IW-1:0] tx_vl_id;

   always #4 clk = ~clk;

   tt_vl_send_sched #(
      .NUM_VL(NV), .TIME_W(TW), .ADDR_W(AW), .LEN_W(LW), .ID_W(IW),
      .CLUSTER_LEN(CL), .VL_PERIOD(PER), .VL_OFFSET(OFF), .VL_ID(IDS)
   ) dut (
      .clk(clk), .rst_n(rst_n), .cyc_time(cyc_time), .time_valid(time_valid),
      .enq_valid(enq_valid), .enq_addr(enq_addr), .enq_len(enq_len), .enq_vl(enq_vl),
      .enq_done(enq_done), .enq_ok(enq_ok), .tx_valid(tx_valid),
      .tx_addr(tx_addr), .tx_len(tx_len), .tx_vl_id(tx_vl_id)
   );

   int          tests = 0;
   int          fails = 0;
   bit          finished = 0;
   string       cur_tag = "R4";
   bit          step_en = 0;
   int          seq = 0;

   // Reference model state
   bit [AW+LW-1:0] mq [NV][$];
   bit [NV-1:0]    mpend = '0;
   bit             m_prev_valid = 0;
   int unsigned    m_prev_t = 0;
   bit             e_tx;
   bit [AW-1:0]    e_addr;
   bit [LW-1:0]    e_len;
   bit [IW-1:0]    e_id;
   bit             e_done;
   bit             e_ok;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, expv, $time);
      end
   endtask

   function automatic int unsigned qdepth(input int unsigned v);
      return CL / PER[v];
   endfunction

   function automatic bit slot_at(input int unsigned v, input int unsigned t);
      return (t < CL) && (((t + CL - OFF[v]) % PER[v]) == 0);
   endfunction

   // One clock: model the edge, then compare away from it
   task automatic cycle();
      bit [NV-1:0] fire;
      bit          newt;
      bit          eok;
      int unsigned t;
      @(posedge clk);
      t    = cyc_time;
      newt = time_valid && (!m_prev_valid || t != m_prev_t);
      fire = '0;
      for (int v = 0; v < NV; v++)
         if (newt && slot_at(v, t) && mq[v].size() > 0)
            fire[v] = 1'b1;
      eok = enq_valid && (enq_vl < NV) && (mq[enq_vl].size() < qdepth(enq_vl));
      e_tx = 1'b0;
      for (int v = 0; v < NV; v++) begin
         if (mpend[v] && !e_tx) begin
            bit [AW+LW-1:0] d;
            d        = mq[v].pop_front();
            e_addr   = d[AW+LW-1:LW];
            e_len    = d[LW-1:0];
            e_id     = IW'(IDS[v]);
            e_tx     = 1'b1;
            mpend[v] = 1'b0;
         end
      end
      if (eok)
         mq[enq_vl].push_back({enq_addr, enq_len});
      mpend        = mpend | fire;
      m_prev_valid = time_valid;
      m_prev_t     = t;
      e_done       = enq_valid;
      e_ok         = eok;
      @(negedge clk);
      chk(tx_valid == e_tx, cur_tag, "tx_valid", tx_valid, e_tx);
      if (e_tx && tx_valid) begin
         chk(tx_addr == e_addr, "R8", "tx_addr", tx_addr, e_addr);
         chk(tx_len == e_len, "R8", "tx_len", tx_len, e_len);
         chk(tx_vl_id == e_id, "R10", "tx_vl_id", tx_vl_id, e_id);
      end
      chk(enq_done == e_done, "R2", "enq_done", enq_done, e_done);
      if (e_done)
         chk(enq_ok == e_ok, e_ok ? "R2" : "R3", "enq_ok", enq_ok, e_ok);
      enq_valid = 1'b0;
      if (step_en)
         cyc_time = TW'((cyc_time + 1) % CL);
   endtask

   task automatic enq(input int unsigned v);
      enq_valid = 1'b1;
      enq_vl    = 2'(v);
      enq_addr  = AW'(16'h1000 + seq);
      enq_len   = LW'(60 + seq);
      seq++;
      cycle();
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++)
         cycle();
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk(tx_valid == 1'b0, "R1", "tx_valid after reset", tx_valid, 0);
      chk(enq_done == 1'b0, "R1", "enq_done after reset", enq_done, 0);

      // R7: fill all queues past depth with the time base not valid
      cur_tag = "R7";
      time_valid = 1'b0;
      cyc_time = '0;
      for (int k = 0; k < 3; k++) enq(0);   // depth 2: third refused (R3)
      for (int k = 0; k < 4; k++) enq(1);   // depth 3
      for (int k = 0; k < 2; k++) enq(2);   // depth 1
      enq(3);                               // out-of-range VL (R3)
      step_en = 1;
      run(30);

      // R6: first synchronized cluster with collisions at ticks 2 and 10
      cur_tag = "R6";
      cyc_time = '0;
      time_valid = 1'b1;
      run(24);

      // R5: empty slots in the second cluster; late and early enqueues
      cur_tag = "R5";
      run(11);           // ticks 0..10 all empty
      enq(2);            // tick 11: after the VL2 slot, waits a full cluster
      enq(1);            // tick 12
      cur_tag = "R4";
      enq(0);            // tick 13, sent at tick 14
      run(10);           // ticks 14..23

      // R5: third cluster sends the late VL2 frame at tick 10
      cur_tag = "R5";
      run(24);

      // R9: held time value reaches a slot once
      cur_tag = "R9";
      step_en = 0;
      time_valid = 1'b0;
      enq(0);
      enq(0);
      cyc_time = 8'd2;
      time_valid = 1'b1;
      run(6);
      cyc_time = 8'd3;
      run(1);
      cyc_time = 8'd2;
      run(4);
      time_valid = 1'b0;
      run(1);
      time_valid = 1'b1;
      run(4);

      // R1: queues drained back to empty, nothing further issued
      cur_tag = "R1";
      for (int v = 0; v < NV; v++)
         chk(mq[v].size() == 0, "R1", "model queue drained", mq[v].size(), 0);
      run(3);

      finished = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

endmodule